// File: doc/BRIEF.md
# Pulse-Coded Programming Target for a Byte Array

This block sits on the device side of an external programming mode. It has no address or command bus. The programmer picks an operation by pulsing a configuration-increment line. The number of pulses taken since the configuration register was last cleared is the operation code. A falling edge on an active-low validate line then commits that operation. The block holds five pieces of state:
- the configuration register;
- an address counter;
- a volatile lock status, which a clear of the address resets to locked;
- a one-time lock cell;
- a small byte array that stands in for the EPROM.

Four operations are defined: read/verify (code 1), unlock (code 2), write (code 3) and lock (code 4). A write can only clear bits. A read is made visible by a low pulse on the config-reset line. The falling edge of that pulse loads the addressed byte into the port register, and the port drives that byte while config-reset is high. All programming lines are asynchronous. They are brought through two-flop synchronizers and edge-detected on the system clock, so each pin event takes effect two to three clocks later.

A simulation-only erase input sets every byte and the lock cell to ones. It models a UV erase.

Top module: `pulse_prog_target`

## Requirements
- R1: After reset, the following hold: curAddr is 0, lockStatus is 0 (locked), errFlag is 0, lastOp is 0, dataOe is 0 and dataOut is 0x00.
- R2: A rising edge of cfgClr clears the configuration register. Each rising edge of cfgInc adds one to it. A validN falling edge commits the operation whose code the register then holds.
- R3: A rising edge of addrClr sets curAddr to 0 and lockStatus to 0. While lockStatus is 1, each rising edge of addrInc adds one to curAddr, wrapping at the array depth. Bytes at different addresses are independent.
- R4: Unlock (code 2) sets lockStatus to 1 only while lockCell is 1. An unlock refused because lockCell is 0 sets errFlag.
- R5: Write (code 3) stores the old byte ANDed with dataIn at curAddr.
- R6: After a read (code 1), the falling edge of cfgClr loads the byte at curAddr into the port register. dataOe equals the synchronized cfgClr level. dataOut shows the port register while dataOe is 1 and is 0x00 otherwise.
- R7: A write clears the port register, so the port drives 0x00 after a write while cfgClr is high.
- R8: While lockStatus is 0, the block ignores address increments and read, write and lock operations, and each such attempt sets errFlag. errFlag stays set until reset.
- R9: Lock (code 4), when lockStatus is 1, writes 0 into lockCell and returns lockStatus to 0. Only the erase input can return lockCell to 1.
- R10: Committing code 0 or any code of 5 and above changes no state and no output.
- R11: lastOp holds the code (1 to 4) of the most recently committed defined operation, whether or not that operation was honoured.
- R12: A high simErase on a clock edge sets every byte of the array and lockCell to 1, so a blank location reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset of the volatile state |
| simErase | input | 1 | Simulation-only whole-array erase |
| cfgClr | input | 1 | Config-reset line; its level also enables the data port |
| cfgInc | input | 1 | Config-increment pulse line |
| validN | input | 1 | Active-low validate line; a falling edge commits the operation |
| addrClr | input | 1 | Address-reset line; a rising edge clears the address and re-locks |
| addrInc | input | 1 | Address-increment pulse line |
| dataIn | input | 8 | Data bus as seen by the block when the port is an input |
| dataOut | output | 8 | Data bus value when driving |
| dataOe | output | 1 | Data port output enable |
| lockStatus | output | 1 | Volatile lock status, 1 = unlocked |
| lockCell | output | 1 | One-time lock cell, 1 = never locked |
| curAddr | output | 6 | Current address counter |
| lastOp | output | 3 | Code of the last defined operation committed |
| errFlag | output | 1 | Sticky refused-operation flag |

## Verification
A wrong lock status shows up at the ports within one operation. A write or read that should have been refused raises errFlag, or the expected byte is missing on the next read-back. A wrong configuration count shows up as a wrong lastOp a few clocks after the validate edge. A wrong address or write merge stays hidden until a later read-back puts a byte on dataOut. The bench therefore reads each written location back and compares it against a value it works out from the AND rule.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_READ   = 3'd1,
    OP_UNLOCK = 3'd2,
    OP_WRITE  = 3'd3,
    OP_LOCK   = 3'd4
  } opCode_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic addrClr;
    logic addrInc;
    logic memWrite;
    logic capture;
    logic outClr;
    logic cellBurn;
  } strobe_t;

  // bit positions in the synchronized input vector
  localparam int IDX_CFGCLR  = 0;
  localparam int IDX_CFGINC  = 1;
  localparam int IDX_VALIDN  = 2;
  localparam int IDX_ADDRCLR = 3;
  localparam int IDX_ADDRINC = 4;
  localparam int NUM_LINES   = 5;
endpackage

// File: rtl/ppt_sync.sv
module ppt_sync #(
  parameter int N = 5,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] rawIn,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : gLine
    logic stage1, stage2, prevLvl;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stage1  <= IDLE[i];
        stage2  <= IDLE[i];
        prevLvl <= IDLE[i];
      end else begin
        stage1  <= rawIn[i];
        stage2  <= stage1;
        prevLvl <= stage2;
      end
    end
    assign level[i] = stage2;
    assign rise[i]  = stage2 & ~prevLvl;
    assign fall[i]  = ~stage2 & prevLvl;
  end
endmodule

// File: rtl/ppt_ctrl.sv
module ppt_ctrl
  import ppt_pkg::*;
#(
  parameter int CFG_W = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgClrRise,
  input  logic          cfgClrFall,
  input  logic          cfgIncRise,
  input  logic          commit,
  input  logic          addrClrRise,
  input  logic          addrIncRise,
  input  logic          lockCell,
  output strobe_t       strobe,
  output logic          lockStatus,
  output opCode_t       lastOp,
  output logic          errFlag
);
  localparam logic [CFG_W-1:0] MAX_CODE = CFG_W'(OP_LOCK);

  logic [CFG_W-1:0] cfgReg;
  logic             readPending;
  logic             definedCode;
  logic [2:0]       code3;
  logic             errHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (cfgClrRise || cfgClrFall) begin
      cfgReg <= '0;
    end else if (cfgIncRise) begin
      cfgReg <= cfgReg + 1'b1;
    end
  end

  assign definedCode = (cfgReg != '0) && (cfgReg <= MAX_CODE);
  assign code3       = cfgReg[2:0];

  always_comb begin
    strobe          = '0;
    errHit          = 1'b0;
    strobe.addrClr  = addrClrRise;
    strobe.addrInc  = addrIncRise && lockStatus && !addrClrRise;
    strobe.capture  = cfgClrFall && readPending;
    if (addrIncRise && !lockStatus) errHit = 1'b1;
    if (commit && definedCode) begin
      unique case (opCode_t'(code3))
        OP_READ:   if (!lockStatus) errHit = 1'b1;
        OP_UNLOCK: if (!lockCell) errHit = 1'b1;
        OP_WRITE: begin
          if (lockStatus) begin
            strobe.memWrite = 1'b1;
            strobe.outClr   = 1'b1;
          end else begin
            errHit = 1'b1;
          end
        end
        OP_LOCK: begin
          if (lockStatus) strobe.cellBurn = 1'b1;
          else            errHit = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockStatus  <= 1'b0;
      readPending <= 1'b0;
      lastOp      <= OP_NONE;
      errFlag     <= 1'b0;
    end else begin
      if (errHit) errFlag <= 1'b1;
      if (addrClrRise || strobe.cellBurn) begin
        lockStatus <= 1'b0;
      end else if (commit && definedCode && opCode_t'(code3) == OP_UNLOCK && lockCell) begin
        lockStatus <= 1'b1;
      end
      if (commit && definedCode) begin
        lastOp      <= opCode_t'(code3);
        readPending <= (opCode_t'(code3) == OP_READ) && lockStatus;
      end else if (cfgClrFall) begin
        readPending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ppt_datapath.sv
module ppt_datapath
  import ppt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              simErase,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] curAddr,
  output logic              lockCell,
  output logic [DATA_W-1:0] portByte
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] readByte;

  assign readByte = mem[curAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
    end else if (strobe.addrClr) begin
      curAddr <= '0;
    end else if (strobe.addrInc) begin
      curAddr <= curAddr + 1'b1;
    end
  end

  // array and lock cell are not touched by reset (non-volatile stand-in)
  always_ff @(posedge clk) begin
    if (simErase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      lockCell <= 1'b1;
    end else begin
      if (strobe.memWrite) mem[curAddr] <= readByte & dataIn;
      if (strobe.cellBurn) lockCell <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portByte <= '0;
    end else if (strobe.outClr) begin
      portByte <= '0;
    end else if (strobe.capture) begin
      portByte <= readByte;
    end
  end
endmodule

// File: rtl/pulse_prog_target.sv
module pulse_prog_target
  import ppt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int CFG_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              simErase,
  input  logic              cfgClr,
  input  logic              cfgInc,
  input  logic              validN,
  input  logic              addrClr,
  input  logic              addrInc,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              lockStatus,
  output logic              lockCell,
  output logic [ADDR_W-1:0] curAddr,
  output logic [2:0]        lastOp,
  output logic              errFlag
);
  localparam logic [NUM_LINES-1:0] IDLE_LVL = NUM_LINES'(1) << IDX_VALIDN;

  logic [NUM_LINES-1:0] rawLines, lvl, rise, fall;
  strobe_t              strobe;
  opCode_t              lastOpEnum;
  logic [DATA_W-1:0]    portByte;

  always_comb begin
    rawLines              = '0;
    rawLines[IDX_CFGCLR]  = cfgClr;
    rawLines[IDX_CFGINC]  = cfgInc;
    rawLines[IDX_VALIDN]  = validN;
    rawLines[IDX_ADDRCLR] = addrClr;
    rawLines[IDX_ADDRINC] = addrInc;
  end

  ppt_sync #(.N(NUM_LINES), .IDLE(IDLE_LVL)) uSync (
    .clk(clk), .rstN(rstN), .rawIn(rawLines),
    .level(lvl), .rise(rise), .fall(fall)
  );

  ppt_ctrl #(.CFG_W(CFG_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgClrRise(rise[IDX_CFGCLR]), .cfgClrFall(fall[IDX_CFGCLR]),
    .cfgIncRise(rise[IDX_CFGINC]), .commit(fall[IDX_VALIDN]),
    .addrClrRise(rise[IDX_ADDRCLR]), .addrIncRise(rise[IDX_ADDRINC]),
    .lockCell(lockCell), .strobe(strobe), .lockStatus(lockStatus),
    .lastOp(lastOpEnum), .errFlag(errFlag)
  );

  ppt_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .simErase(simErase), .strobe(strobe),
    .dataIn(dataIn), .curAddr(curAddr), .lockCell(lockCell),
    .portByte(portByte)
  );

  assign lastOp  = 3'(lastOpEnum);
  assign dataOe  = lvl[IDX_CFGCLR];
  assign dataOut = dataOe ? portByte : '0;
endmodule

// File: rtl/ppt_checker.sv
module ppt_checker #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              simErase,
  input logic              lockStatus,
  input logic              lockCell,
  input logic              errFlag,
  input logic              dataOe,
  input logic [DATA_W-1:0] dataOut,
  input logic [ADDR_W-1:0] curAddr
);
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (curAddr != $past(curAddr)) |-> (curAddr == '0 || curAddr == $past(curAddr) + 1'b1)); // R3
  AST_UNLOCK_NEEDS_CELL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockStatus) |-> $past(lockCell)); // R4
  AST_PORT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == '0)); // R6
  AST_LOCKED_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !lockStatus |=> (curAddr == $past(curAddr) || curAddr == '0)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R8
  AST_CELL_ONE_WAY: assert property (@(posedge clk) disable iff (!rstN)
    (!lockCell && !simErase) |=> !lockCell); // R9
endmodule

bind pulse_prog_target ppt_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .simErase(simErase), .lockStatus(lockStatus),
  .lockCell(lockCell), .errFlag(errFlag), .dataOe(dataOe),
  .dataOut(dataOut), .curAddr(curAddr)
);

// File: tb/sim_pulse_prog_target.sv
module sim_pulse_prog_target;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       simErase = 1'b0;
  logic       cfgClr = 1'b0;
  logic       cfgInc = 1'b0;
  logic       validN = 1'b1;
  logic       addrClr = 1'b0;
  logic       addrInc = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] dataOut;
  logic       dataOe, lockStatus, lockCell, errFlag;
  logic [5:0] curAddr;
  logic [2:0] lastOp;
  int         errors = 0;
  int         checks = 0;

  always #10 clk = ~clk;

  pulse_prog_target u0 (
    .clk(clk), .rstN(rstN), .simErase(simErase), .cfgClr(cfgClr),
    .cfgInc(cfgInc), .validN(validN), .addrClr(addrClr), .addrInc(addrInc),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .lockStatus(lockStatus), .lockCell(lockCell), .curAddr(curAddr),
    .lastOp(lastOp), .errFlag(errFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadAndCommit(input int code);
    cfgClr = 1'b0; settle(5);
    cfgClr = 1'b1; settle(5);
    for (int i = 0; i < code; i++) begin
      cfgInc = 1'b1; settle(3);
      cfgInc = 1'b0; settle(3);
    end
    validN = 1'b0; settle(5);
    validN = 1'b1; settle(5);
  endtask

  task automatic pulseAddrInc(input int n);
    for (int i = 0; i < n; i++) begin
      addrInc = 1'b1; settle(3);
      addrInc = 1'b0; settle(3);
    end
  endtask

  task automatic pulseAddrClr();
    addrClr = 1'b0; settle(3);
    addrClr = 1'b1; settle(5);
  endtask

  // read op then low pulse on cfgClr; returns driven byte
  task automatic readBack(output logic [7:0] val);
    loadAndCommit(1);
    cfgClr = 1'b0; settle(5);
    cfgClr = 1'b1; settle(5);
    val = dataOut;
  endtask

  task automatic writeByte(input logic [7:0] d);
    dataIn = d;
    loadAndCommit(3);
  endtask

  task automatic testReset();
    check("R1 addr", 32'(curAddr), 0);
    check("R1 lockStatus", 32'(lockStatus), 0);
    check("R1 errFlag", 32'(errFlag), 0);
    check("R1 lastOp", 32'(lastOp), 0);
    check("R1 dataOe", 32'(dataOe), 0);
    check("R1 dataOut", 32'(dataOut), 0);
    check("R12 cell after erase", 32'(lockCell), 1);
  endtask

  task automatic testBlankUnlock();
    logic [7:0] v;
    pulseAddrClr();
    loadAndCommit(2);
    check("R4 unlock", 32'(lockStatus), 1);
    check("R11 lastOp unlock", 32'(lastOp), 2);
    loadAndCommit(1);
    cfgClr = 1'b0; settle(5);
    check("R6 port released", 32'(dataOe), 0);
    check("R6 quiet value", 32'(dataOut), 0);
    cfgClr = 1'b1; settle(5);
    check("R6 port drives", 32'(dataOe), 1);
    check("R12 blank reads ones", 32'(dataOut), 32'hFF);
    readBack(v);
    check("R6 repeat read", 32'(v), 32'hFF);
  endtask

  task automatic testWrite();
    logic [7:0] v;
    writeByte(8'hA5);
    check("R7 port after write", 32'(dataOut), 0);
    check("R11 lastOp write", 32'(lastOp), 3);
    readBack(v);
    check("R5 first write", 32'(v), 32'hA5);
    writeByte(8'h3C);
    readBack(v);
    check("R5 AND merge", 32'(v), 32'h24);
  endtask

  task automatic testAddress();
    logic [7:0] v;
    pulseAddrInc(3);
    check("R3 addr inc", 32'(curAddr), 3);
    writeByte(8'h0F);
    readBack(v);
    check("R3 write at 3", 32'(v), 32'h0F);
    pulseAddrInc(61);
    check("R3 addr wrap", 32'(curAddr), 0);
    readBack(v);
    check("R3 addr0 kept", 32'(v), 32'h24);
    pulseAddrInc(2);
    pulseAddrClr();
    check("R3 clear addr", 32'(curAddr), 0);
    check("R3 clear relocks", 32'(lockStatus), 0);
    check("R8 no error yet", 32'(errFlag), 0);
  endtask

  task automatic testCfgAndUnused();
    loadAndCommit(2);
    // two pulses, then a fresh clear, then one pulse: must commit read
    cfgClr = 1'b0; settle(5);
    cfgClr = 1'b1; settle(5);
    cfgInc = 1'b1; settle(3); cfgInc = 1'b0; settle(3);
    cfgInc = 1'b1; settle(3); cfgInc = 1'b0; settle(3);
    cfgClr = 1'b0; settle(5);
    cfgClr = 1'b1; settle(5);
    cfgInc = 1'b1; settle(3); cfgInc = 1'b0; settle(3);
    validN = 1'b0; settle(5); validN = 1'b1; settle(5);
    check("R2 clear then count", 32'(lastOp), 1);
    loadAndCommit(6);
    check("R10 code 6 lastOp", 32'(lastOp), 1);
    loadAndCommit(0);
    check("R10 code 0 lastOp", 32'(lastOp), 1);
    check("R10 no error", 32'(errFlag), 0);
    check("R10 lock kept", 32'(lockStatus), 1);
    check("R10 cell kept", 32'(lockCell), 1);
  endtask

  task automatic testLockedOps();
    logic [7:0] v;
    pulseAddrClr();
    pulseAddrInc(2);
    check("R8 inc ignored", 32'(curAddr), 0);
    check("R8 err set", 32'(errFlag), 1);
    writeByte(8'h00);
    check("R11 refused write logged", 32'(lastOp), 3);
    loadAndCommit(2);
    readBack(v);
    check("R8 write ignored", 32'(v), 32'h24);
    check("R8 err sticky", 32'(errFlag), 1);
  endtask

  task automatic testLock();
    logic [7:0] v;
    loadAndCommit(4);
    check("R9 cell burnt", 32'(lockCell), 0);
    check("R9 status locked", 32'(lockStatus), 0);
    loadAndCommit(2);
    check("R4 unlock refused", 32'(lockStatus), 0);
    @(negedge clk); simErase = 1'b1; @(negedge clk); simErase = 1'b0;
    settle(2);
    check("R12 cell restored", 32'(lockCell), 1);
    pulseAddrClr();
    loadAndCommit(2);
    check("R4 unlock after erase", 32'(lockStatus), 1);
    readBack(v);
    check("R12 erased byte", 32'(v), 32'hFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    simErase = 1'b1;
    settle(3);
    simErase = 1'b0;
    settle(2);
    rstN = 1'b1;
    settle(2);
    testReset();
    testBlankUnlock();
    testWrite();
    testAddress();
    testCfgAndUnused();
    testLockedOps();
    testLock();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule